// File: doc/BRIEF.md
# Coin-Operated Laundry Sequencing Controller

This block is the sequencing brain of a coin-operated washer. It sits idle until a coin event arrives, then walks the drum through its stages: soak, wash, rinse and finally spin, after which it goes back to waiting. A switch on the front panel selects an extra wash and rinse pass, which is inserted after the first rinse and before spin. An external interval timer supplies a one-cycle expiry pulse. Each stage lasts one timer period, and the controller only moves on when that pulse arrives.

A lid interlock guards the spin stage. While the lid is up during spin, the motor enable drops and the controller holds its place. The external timer is frozen during that time, and any expiry pulse that still arrives is discarded. Once the lid is shut again, spinning resumes. The stage indicators are one-hot and are decoded from the state register. A busy flag marks any running cycle.

The reset input is asynchronous and active-low. Asserting it clears the machine at once. Its release is synchronised to the clock, so the first stage change can happen only after the synchroniser chain has filled.

Top module: `laundry_seq`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, all four stage indicators, the motor enable and busy are low.
- R2: In idle, a coin pulse moves the machine to soak at the next clock edge. The stage vector then reads 4'b0001 (bit 0 = soak, bit 1 = wash, bit 2 = rinse, bit 3 = spin) and busy goes high.
- R3: With the extra-pass switch low, successive timer pulses step the machine soak, wash, rinse, spin and then back to idle, where busy is low.
- R4: In any running stage, a cycle without a timer pulse leaves the stage unchanged.
- R5: If the switch is high on the timer pulse that ends the first rinse, the machine runs a second wash and a second rinse, then spin, whatever the switch reads during the second pass. The switch value at any other moment has no effect on the path taken.
- R6: A timer pulse in idle, without a coin, leaves the machine idle.
- R7: A coin pulse during a running cycle has no effect on the stage.
- R8: The lid input has no effect on the stage or on any output in soak, wash or rinse.
- R9: The motor enable is high exactly when the stage is spin and the lid is closed. It drops in the same cycle the lid opens and returns in the same cycle the lid closes.
- R10: A timer pulse that arrives while the lid is open during spin is ignored, and the machine stays in spin.
- R11: Pulling reset low forces idle outputs at once, without waiting for a clock edge. After release, a coin held high is first accepted on the (RST_SYNC_STAGES+1)-th rising edge.
- R12: Whenever busy is high, exactly one stage indicator is high. Whenever busy is low, none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coin_i | input | 1 | Coin-deposit event, one cycle |
| tmr_done_i | input | 1 | Expiry pulse from the external interval timer |
| dbl_wash_i | input | 1 | Extra wash-and-rinse pass select switch |
| lid_open_i | input | 1 | High while the lid is raised |
| stage_oh_o | output | 4 | One-hot stage: bit 0 soak, 1 wash, 2 rinse, 3 spin |
| spin_motor_o | output | 1 | Spin motor enable |
| busy_o | output | 1 | High while a cycle is in progress |

## Verification
The bound checker watches, on every cycle, the properties that hold between neighbouring cycles. These are the one-hot shape of the stage vector against busy, the coin start from idle, the idle and no-pulse holds, coin rejection while running, the lid hold in spin, the motor gating, and the return to idle after spin. The full stage orderings need the bench's directed scenarios. These include the choice made at the end of the first rinse, the switch being ignored everywhere else, the lid having no effect outside spin, and the immediate clear on reset assertion together with the delayed acceptance after release.

// File: rtl/laundry_pkg.sv
package laundry_pkg;

  localparam int unsigned NUM_STAGES = 4;
  localparam int unsigned STG_SOAK   = 0;
  localparam int unsigned STG_WASH   = 1;
  localparam int unsigned STG_RINSE  = 2;
  localparam int unsigned STG_SPIN   = 3;

  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_SOAK   = 3'd1,
    ST_WASH1  = 3'd2,
    ST_RINSE1 = 3'd3,
    ST_WASH2  = 3'd4,
    ST_RINSE2 = 3'd5,
    ST_SPIN   = 3'd6
  } wash_state_t;

endpackage

// File: rtl/laundry_rst_sync.sv
module laundry_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  // Asynchronous clear, synchronous release through a flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= 1'b1;
      for (int i = 1; i <= int'(LAST); i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/laundry_next_state.sv
module laundry_next_state
  import laundry_pkg::*;
(
  input  wash_state_t cur_state,
  input  logic        coin,
  input  logic        tmr_done,
  input  logic        dbl_wash,
  input  logic        lid_open,
  output wash_state_t nxt_state,
  output logic        state_en
);

  logic spin_paused;
  logic advance;

  // A raised lid only freezes the spin stage; elsewhere it is ignored.
  assign spin_paused = (cur_state == ST_SPIN) && lid_open;
  assign advance     = tmr_done && !spin_paused;

  always_comb begin
    nxt_state = cur_state;
    unique case (cur_state)
      ST_IDLE:   if (coin)    nxt_state = ST_SOAK;
      ST_SOAK:   if (advance) nxt_state = ST_WASH1;
      ST_WASH1:  if (advance) nxt_state = ST_RINSE1;
      ST_RINSE1: if (advance) nxt_state = dbl_wash ? ST_WASH2 : ST_SPIN;
      ST_WASH2:  if (advance) nxt_state = ST_RINSE2;
      ST_RINSE2: if (advance) nxt_state = ST_SPIN;
      ST_SPIN:   if (advance) nxt_state = ST_IDLE;
      default:                nxt_state = ST_IDLE;
    endcase
  end

  assign state_en = (nxt_state != cur_state);

endmodule

// File: rtl/laundry_state_reg.sv
module laundry_state_reg
  import laundry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  wash_state_t d,
  output wash_state_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= ST_IDLE;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/laundry_out_dec.sv
module laundry_out_dec
  import laundry_pkg::*;
(
  input  wash_state_t           cur_state,
  input  logic                  lid_open,
  output logic [NUM_STAGES-1:0] stage_oh,
  output logic                  spin_motor,
  output logic                  busy
);

  always_comb begin
    stage_oh = '0;
    unique case (cur_state)
      ST_SOAK:             stage_oh[STG_SOAK]  = 1'b1;
      ST_WASH1, ST_WASH2:  stage_oh[STG_WASH]  = 1'b1;
      ST_RINSE1, ST_RINSE2: stage_oh[STG_RINSE] = 1'b1;
      ST_SPIN:             stage_oh[STG_SPIN]  = 1'b1;
      default:             stage_oh = '0;
    endcase
  end

  assign busy       = (cur_state != ST_IDLE);
  assign spin_motor = (cur_state == ST_SPIN) && !lid_open;

endmodule

// File: rtl/laundry_seq.sv
module laundry_seq
  import laundry_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  coin_i,
  input  logic                  tmr_done_i,
  input  logic                  dbl_wash_i,
  input  logic                  lid_open_i,
  output logic [NUM_STAGES-1:0] stage_oh_o,
  output logic                  spin_motor_o,
  output logic                  busy_o
);

  logic        rst_sync_n;
  wash_state_t cur_state;
  wash_state_t nxt_state;
  logic        state_en;

  laundry_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  laundry_next_state u_next (
    .cur_state(cur_state),
    .coin     (coin_i),
    .tmr_done (tmr_done_i),
    .dbl_wash (dbl_wash_i),
    .lid_open (lid_open_i),
    .nxt_state(nxt_state),
    .state_en (state_en)
  );

  laundry_state_reg u_state (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (state_en),
    .d    (nxt_state),
    .q    (cur_state)
  );

  laundry_out_dec u_dec (
    .cur_state (cur_state),
    .lid_open  (lid_open_i),
    .stage_oh  (stage_oh_o),
    .spin_motor(spin_motor_o),
    .busy      (busy_o)
  );

endmodule

// File: rtl/laundry_seq_chk.sv
module laundry_seq_chk
  import laundry_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  coin_i,
  input logic                  tmr_done_i,
  input logic                  lid_open_i,
  input logic [NUM_STAGES-1:0] stage_oh_o,
  input logic                  spin_motor_o,
  input logic                  busy_o
);

  // R12
  p_onehot_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(stage_oh_o) == 1));

  // R12
  p_idle_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (stage_oh_o == '0));

  // R2
  p_coin_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && coin_i) |=> (stage_oh_o == 4'b0001));

  // R6
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !coin_i) |=> !busy_o);

  // R4, R7
  p_no_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tmr_done_i) |=> (busy_o && $stable(stage_oh_o)));

  // R10
  p_lid_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_oh_o[STG_SPIN] && lid_open_i) |=> stage_oh_o[STG_SPIN]);

  // R9
  p_motor_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spin_motor_o |-> (stage_oh_o[STG_SPIN] && !lid_open_i));

  // R9
  p_motor_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_oh_o[STG_SPIN] && !lid_open_i) |-> spin_motor_o);

  // R3
  p_spin_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_oh_o[STG_SPIN] && tmr_done_i && !lid_open_i) |=> !busy_o);

endmodule

bind laundry_seq laundry_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .coin_i      (coin_i),
  .tmr_done_i  (tmr_done_i),
  .lid_open_i  (lid_open_i),
  .stage_oh_o  (stage_oh_o),
  .spin_motor_o(spin_motor_o),
  .busy_o      (busy_o)
);

// File: tb/laundry_seq_tb.sv
module laundry_seq_tb;

  localparam int unsigned SYNC = 2;
  localparam logic [3:0] S_IDLE  = 4'b0000;
  localparam logic [3:0] S_SOAK  = 4'b0001;
  localparam logic [3:0] S_WASH  = 4'b0010;
  localparam logic [3:0] S_RINSE = 4'b0100;
  localparam logic [3:0] S_SPIN  = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coin = 1'b0;
  logic       tmr = 1'b0;
  logic       dbl = 1'b0;
  logic       lid = 1'b0;
  logic [3:0] stage;
  logic       motor;
  logic       busy;

  int n_tests = 0;
  int n_fail  = 0;
  logic  done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  laundry_seq #(.RST_SYNC_STAGES(SYNC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .coin_i      (coin),
    .tmr_done_i  (tmr),
    .dbl_wash_i  (dbl),
    .lid_open_i  (lid),
    .stage_oh_o  (stage),
    .spin_motor_o(motor),
    .busy_o      (busy)
  );

  task automatic check_now(input logic [3:0] es, input logic em, input logic eb, input string tag);
    n_tests++;
    if ({stage, motor, busy} !== {es, em, eb}) begin
      n_fail++;
      $display("FAIL %s: got stage=%b motor=%b busy=%b, expected stage=%b motor=%b busy=%b",
               tag, stage, motor, busy, es, em, eb);
    end
  endtask

  // Drive inputs at a falling edge; expect results after the next rising edge.
  task automatic cyc(input logic c, input logic t, input logic d, input logic l,
                     input logic [3:0] es, input logic em, input logic eb, input string tag);
    @(negedge clk);
    coin = c; tmr = t; dbl = d; lid = l;
    exp_q.push_back({es, em, eb});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one queued item per cycle just after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string      tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check_now(e[5:2], e[1], e[0], tg);
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    coin = 0; tmr = 0; dbl = 0; lid = 0;
    @(posedge clk);
    #3;
  endtask

  initial begin
    #3;
    check_now(S_IDLE, 1'b0, 1'b0, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < int'(SYNC); i++) cyc(0, 0, 0, 0, S_IDLE, 0, 0, "R1 release");

    // Single pass with idle-pulse, hold, coin and lid corner cases
    cyc(0, 1, 0, 0, S_IDLE,  0, 0, "R6");
    cyc(1, 0, 0, 0, S_SOAK,  0, 1, "R2");
    cyc(0, 0, 0, 0, S_SOAK,  0, 1, "R4");
    cyc(1, 0, 0, 0, S_SOAK,  0, 1, "R7");
    cyc(0, 0, 0, 1, S_SOAK,  0, 1, "R8 soak");
    cyc(0, 1, 1, 0, S_WASH,  0, 1, "R3 wash");
    cyc(0, 0, 0, 1, S_WASH,  0, 1, "R8 wash");
    cyc(0, 1, 1, 1, S_RINSE, 0, 1, "R8 rinse advance");
    cyc(0, 0, 0, 0, S_RINSE, 0, 1, "R12");
    cyc(0, 1, 0, 0, S_SPIN,  1, 1, "R5 switch low");
    cyc(1, 0, 0, 1, S_SPIN,  0, 1, "R9 lid up");
    cyc(0, 1, 0, 1, S_SPIN,  0, 1, "R10");
    cyc(0, 0, 0, 0, S_SPIN,  1, 1, "R9 lid down");
    cyc(0, 1, 0, 0, S_IDLE,  0, 0, "R3 spin end");
    cyc(0, 0, 0, 0, S_IDLE,  0, 0, "R6 hold");

    // Extra pass selected only at the end of the first rinse
    cyc(1, 0, 0, 0, S_SOAK,  0, 1, "R2 second run");
    cyc(0, 1, 0, 0, S_WASH,  0, 1, "R3");
    cyc(0, 1, 0, 0, S_RINSE, 0, 1, "R3");
    cyc(0, 1, 1, 0, S_WASH,  0, 1, "R5 second wash");
    cyc(0, 1, 0, 0, S_RINSE, 0, 1, "R5 second rinse");
    cyc(0, 0, 0, 1, S_RINSE, 0, 1, "R8 second rinse");
    cyc(0, 1, 1, 0, S_SPIN,  1, 1, "R5 spin after pass two");
    cyc(0, 1, 0, 0, S_IDLE,  0, 0, "R3");

    // Asynchronous reset in the middle of a run
    cyc(1, 0, 0, 0, S_SOAK,  0, 1, "R2");
    cyc(0, 1, 0, 0, S_WASH,  0, 1, "R3");
    drain();
    check_now(S_WASH, 1'b0, 1'b1, "R11 before reset");
    #1 rst_n = 1'b0;
    #1 check_now(S_IDLE, 1'b0, 1'b0, "R11 immediate");
    @(negedge clk);
    rst_n = 1'b1;
    coin = 1'b1;
    exp_q.push_back({S_IDLE, 1'b0, 1'b0});
    tag_q.push_back("R11 sync release");
    for (int i = 1; i < int'(SYNC); i++) cyc(1, 0, 0, 0, S_IDLE, 0, 0, "R11 sync release");
    cyc(1, 0, 0, 0, S_SOAK, 0, 1, "R11 first accept");
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule